// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital core of a successive-approximation analog-to-digital converter. A falling edge on the start command begins a conversion and raises the status flag. A divided bit clock then runs as a gated burst. On each rising bit-clock edge the sequencer takes the keep/reject decision for one bit from a single comparator input. At the same edge it offers the next lower bit to the external DAC. The bits are resolved from the most significant downwards.

The trial register is negative-true. A bit under test is driven low, and a bit that is not set reads high. The register drives the DAC and is also the parallel result. A second output carries the complement of the register MSB. Bipolar users take it as the sign bit to get complementary two's-complement coding, or take the register MSB directly for complementary offset binary. A per-conversion length input stops the sequence early after fewer decisions.

The status flag falls a fixed number of system-clock cycles after the last decision. The result is therefore already stable when status falls, and a downstream register can capture it on that falling edge.

Top module: `sar_seq`

## Requirements
- R1: While status is low, a falling edge on start_i (high at one system-clock edge, low at the next) sets status_o at that second edge. At the same edge every bit of res_n_o becomes 1, which means true zero.
- R2: A falling edge on start_i while status_o is high is ignored: the running conversion keeps its timing and its result.
- R3: After reset, status_o is 0, bclk_o is 0, res_n_o is all ones and msb_n_o is 0.
- R4: bclk_o is 0 whenever status_o is 0. While a conversion runs, bclk_o has a period of 2*HALF system clocks, its first rising edge comes one system clock after status rises, and a conversion of L bits shows exactly L+1 rising edges.
- R5: At the first bit-clock rise, res_n_o bit NB-1 goes to 0 and all other bits stay 1. At rise k+1 (k from 1 to L), bit NB-k keeps 0 if cmp_i was 1, or returns to 1 if cmp_i was 0. At that same rise, bit NB-k-1 goes to 0 if k < L.
- R6: cmp_i is 1 when the analog input is at or above the trial value, and the trial value is the bitwise complement of res_n_o.
- R7: A full-length conversion of input code V ends with res_n_o equal to the bitwise complement of V (complementary straight binary).
- R8: len_i is sampled when a conversion is accepted. A value from 1 to NB sets the number of decisions L, and a value of 0 or above NB gives L = NB. The NB-L low bits of res_n_o stay 1.
- R9: status_o falls exactly SETTLE system clocks after the rise that carries the last decision. res_n_o does not change from that rise until the next conversion is accepted.
- R10: msb_n_o is the complement of res_n_o bit NB-1, so it equals the true MSB of the result.
- R11: While status stays high, res_n_o changes only at the system-clock edge where bclk_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Convert command; a conversion starts on its falling edge |
| cmp_i | input | 1 | Comparator: 1 when the analog input is at or above the trial value |
| len_i | input | $clog2(NB+1) | Number of bits to resolve (0 or above NB means NB) |
| res_n_o | output | NB | Negative-true trial register and result, also the DAC drive |
| msb_n_o | output | 1 | Complement of the result MSB |
| status_o | output | 1 | High while a conversion is in progress |
| bclk_o | output | 1 | Gated bit clock |

## Verification
Several properties are checked by assertions on every cycle:
- bclk_o stays low while status is low.
- res_n_o changes only on a bit-clock rise, and by at most two bits.
- A rise leaves bclk_o high.
- The result stays frozen once the last decision is taken and when status falls.
- The number of bit-clock rises matches the sampled length.

Other properties only the bench scenarios can show. These are the exact decision made against a modelled analog input at every rise, the complemented code across every input value, and the early stop and length clamping. They also include the exact status duration and the ignoring of a second start edge in the middle of a conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  // clamp a requested bit count to 1..nb
  function automatic int unsigned clamp_len(input int unsigned req, input int unsigned nb);
    return (req == 0 || req > nb) ? nb : req;
  endfunction

endpackage

// File: rtl/sar_start_edge.sv
module sar_start_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic fall_o
);

  logic start_s;
  logic start_q;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign start_s = start_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2+1-1:0], start_i};
      end
      assign start_s = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= start_s;
  end

  assign fall_o = start_q & ~start_s;

endmodule

// File: rtl/sar_bit_timer.sv
module sar_bit_timer #(
  parameter int unsigned HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  input  logic en_d_i,
  input  logic done_i,
  output logic rise_o,
  output logic bclk_o
);

  localparam int unsigned DIV2 = 2 * HALF;
  localparam int unsigned CW   = (DIV2 > 1) ? $clog2(DIV2) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV2 - 1);

  logic [CW-1:0] div_q, div_d;
  logic          bclk_q;

  always_comb begin
    if (load_i)                       div_d = LAST;
    else if (!en_d_i)                 div_d = '0;
    else if (done_i && div_q == LAST) div_d = div_q; // park low after last pulse
    else if (div_q == LAST)           div_d = '0;
    else                              div_d = div_q + 1'b1;
  end

  assign rise_o = run_i && !done_i && (div_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      bclk_q <= en_d_i && !load_i && (32'(div_d) < HALF);
    end
  end

  assign bclk_o = bclk_q;

  AST_RISE_FROM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> !bclk_q);  // R4
  AST_RISE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> bclk_q);  // R4

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
  import sar_seq_pkg::*;
#(
  parameter int unsigned NB = 12,
  parameter int unsigned LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          rise_i,
  input  logic          cmp_i,
  input  logic [LW-1:0] len_i,
  output logic [NB-1:0] data_o,
  output logic [LW-1:0] len_o,
  output logic          done_o,
  output logic          last_o
);

  logic [NB-1:0] data_q, data_d;
  logic [LW-1:0] step_q, step_d;
  logic [LW-1:0] len_q, len_d;
  logic          done_q, done_d;

  always_comb begin
    data_d = data_q;
    step_d = step_q;
    len_d  = len_q;
    done_d = done_q;
    if (load_i) begin
      data_d = '1;
      step_d = '0;
      done_d = 1'b0;
      len_d  = LW'(clamp_len(32'(len_i), NB));
    end else if (rise_i && !done_q) begin
      if (step_q == '0) begin
        data_d[NB-1] = 1'b0;
      end else begin
        for (int i = 0; i < NB; i++) begin
          if (i == NB - 32'(step_q) && !cmp_i) data_d[i] = 1'b1;      // reject
          if (step_q < len_q && i == NB - 32'(step_q) - 1) data_d[i] = 1'b0; // next trial
        end
        if (step_q == len_q) done_d = 1'b1;
      end
      step_d = step_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '1;
      step_q <= '0;
      len_q  <= LW'(NB);
      done_q <= 1'b0;
    end else begin
      data_q <= data_d;
      step_q <= step_d;
      len_q  <= len_d;
      done_q <= done_d;
    end
  end

  assign data_o = data_q;
  assign len_o  = len_q;
  assign done_o = done_q;
  assign last_o = rise_i && !done_q && (step_q != '0) && (step_q == len_q);

  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !done_q && !load_i) |=> ($countones(data_q ^ $past(data_q)) <= 2));  // R5
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !load_i) |=> $stable(data_q));  // R9
  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q != '0) && (32'(len_q) <= NB));  // R8

endmodule

// File: rtl/sar_settle.sv
module sar_settle #(
  parameter int unsigned SETTLE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic clr_o
);

  localparam int unsigned CW = $clog2(SETTLE + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (arm_i)          cnt_q <= CW'(SETTLE);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign clr_o = (cnt_q == CW'(1));

  AST_SETTLE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !clr_o);  // R9

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int unsigned NB          = 12,
  parameter int unsigned HALF        = 4,
  parameter int unsigned SETTLE      = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LW         = $clog2(NB + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cmp_i,
  input  logic [LW-1:0] len_i,
  output logic [NB-1:0] res_n_o,
  output logic          msb_n_o,
  output logic          status_o,
  output logic          bclk_o
);

  logic start_fall, accept;
  logic status_q, status_d;
  logic rise, done, last, settle_clr;
  logic [LW-1:0] len_eff;

  sar_start_edge #(.SYNC_STAGES(SYNC_STAGES)) u_start (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .fall_o (start_fall)
  );

  assign accept = start_fall && !status_q;

  always_comb begin
    status_d = status_q;
    if (accept)          status_d = 1'b1;
    else if (settle_clr) status_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= 1'b0;
    else         status_q <= status_d;
  end

  sar_bit_timer #(.HALF(HALF)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .run_i  (status_q),
    .en_d_i (status_d),
    .done_i (done),
    .rise_o (rise),
    .bclk_o (bclk_o)
  );

  sar_trial_reg #(.NB(NB), .LW(LW)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .rise_i (rise),
    .cmp_i  (cmp_i),
    .len_i  (len_i),
    .data_o (res_n_o),
    .len_o  (len_eff),
    .done_o (done),
    .last_o (last)
  );

  sar_settle #(.SETTLE(SETTLE)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (last),
    .clr_o  (settle_clr)
  );

  assign status_o = status_q;
  assign msb_n_o  = ~res_n_o[NB-1];

  // rise counter used only by the edge-count property
  logic [LW:0] rise_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rise_cnt_q <= '0;
    else if (accept)              rise_cnt_q <= '0;
    else if ($rose(bclk_o))       rise_cnt_q <= rise_cnt_q + 1'b1;
  end

  AST_START_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_fall && !status_q) |=> (status_o && (res_n_o == '1)));  // R1
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_fall && status_q && !settle_clr) |=> status_o);  // R2
  AST_CLK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o |-> !bclk_o);  // R4
  AST_EDGE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o) |-> (rise_cnt_q == {1'b0, len_eff} + 1'b1));  // R4
  AST_FALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o) |-> $stable(res_n_o));  // R9
  AST_DATA_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && $past(status_o) && !$stable(res_n_o)) |-> $rose(bclk_o));  // R11

endmodule

// File: tb/sar_seq_tb.sv
module sar_seq_tb;

  localparam int unsigned NB     = 12;
  localparam int unsigned HALF   = 1;
  localparam int unsigned SETTLE = 3;
  localparam int unsigned DIV2   = 2 * HALF;
  localparam int unsigned LW     = $clog2(NB + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          cmp;
  logic [LW-1:0] len = '0;
  logic [NB-1:0] res_n;
  logic          msb_n, status, bclk;
  logic [NB-1:0] vin = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // R6: analog model, trial value is the complement of the register
  assign cmp = (vin >= ~res_n);

  sar_seq #(.NB(NB), .HALF(HALF), .SETTLE(SETTLE), .SYNC_STAGES(0)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .cmp_i   (cmp),
    .len_i   (len),
    .res_n_o (res_n),
    .msb_n_o (msb_n),
    .status_o(status),
    .bclk_o  (bclk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int unsigned eff_len(input int unsigned l);
    return (l == 0 || l > NB) ? NB : l;
  endfunction

  function automatic logic [NB-1:0] top_mask(input int unsigned k);
    logic [NB-1:0] m = '0;
    for (int i = 0; i < NB; i++) if (i >= NB - k) m[i] = 1'b1;
    return m;
  endfunction

  // true-coded register value after bit-clock rise r
  function automatic logic [NB-1:0] trace_val(input logic [NB-1:0] v, input int unsigned le,
                                              input int unsigned r);
    logic [NB-1:0] t = v & top_mask(r - 1);
    if (r <= le) t[NB-r] = 1'b1;
    return t;
  endfunction

  task automatic run_conv(input logic [NB-1:0] v, input int unsigned l, input bit inj);
    int unsigned le = eff_len(l);
    int hi = 1, rises = 0, terr = 0, herr = 0;
    logic pb;
    logic [NB-1:0] pd;
    logic [NB-1:0] exp_true = v & top_mask(le);
    @(negedge clk);
    vin = v; len = LW'(l); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(status && res_n == '1 && !bclk, "R1 start accepted", {status, res_n}, {1'b1, {NB{1'b1}}});
    pd = res_n; pb = bclk;
    forever begin
      @(negedge clk);
      if (inj && hi == 5) start = 1'b1;
      if (inj && hi == 9) start = 1'b0;
      if (!status) break;
      hi++;
      if (bclk && !pb) begin
        rises++;
        if (hi != 2 + (rises - 1) * DIV2) terr++;
        if (res_n != ~trace_val(v, le, rises)) terr++;
      end else if (res_n != pd) herr++;
      pd = res_n; pb = bclk;
    end
    start = 1'b0;
    chk(terr == 0, "R5 per-rise trial/decision trace", terr, 0);
    chk(herr == 0, "R11 no change between rises", herr, 0);
    chk(rises == le + 1, "R4 bit-clock rise count", rises, le + 1);
    chk(!bclk, "R4 clock gated when idle", bclk, 0);
    chk(hi == 1 + le * DIV2 + SETTLE, inj ? "R2/R9 status duration" : "R9 status duration",
        hi, 1 + le * DIV2 + SETTLE);
    chk(res_n == ~exp_true, inj ? "R2 result with ignored start" : "R6/R7/R8 result",
        res_n, ~exp_true);
    chk(msb_n == exp_true[NB-1], "R10 inverted msb", msb_n, exp_true[NB-1]);
  endtask

  initial begin
    int unsigned l;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!status && !bclk && res_n == '1 && !msb_n, "R3 reset state",
        {status, bclk, msb_n, res_n}, {3'b000, {NB{1'b1}}});
    // directed corners
    run_conv(12'h000, 12, 0);
    run_conv(12'hFFF, 12, 0);
    run_conv(12'h800, 12, 0);
    run_conv(12'h7FF, 12, 0);
    run_conv(12'hABC, 10, 0);   // R8
    run_conv(12'hABC, 8, 0);    // R8
    run_conv(12'hFFF, 1, 0);    // R8
    run_conv(12'h5A5, 0, 0);    // R8 clamp
    run_conv(12'h5A5, 15, 0);   // R8 clamp
    run_conv(12'h3C3, 12, 1);   // R2
    // full sweep
    for (int c = 0; c < (1 << NB); c++) run_conv(NB'(c), 12, 0);
    // random
    for (int k = 0; k < 300; k++) begin
      l = $urandom % 16;
      run_conv(NB'($urandom), l, (eff_len(l) >= 4) && ($urandom % 2 == 1));
    end
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule